// File: doc/BRIEF.md
# Context-Tagged Translation Buffer with Invalidation Sweep

This block is a small fully associative translation cache for a processor that runs guests. Each resident entry records the virtual-processor identifier (VPID) under which it was created, whether second-level translation was active at that moment, and, if so, the page-frame field of the second-level root pointer. It also keeps the linear page number, the physical page number and a global flag. A combinational lookup port compares a linear page against the current context and returns hit and the physical page. A fill port installs new translations under the current context.

Software-driven invalidations arrive on a command port as a two-bit kind, a VPID and a linear page. The block accepts one command while idle. It then walks the entries, one per clock, clears those the kind selects and pulses done. Page walking, permission checks and command decoding sit outside this block.

Top module: `ctx_tlb`

## Requirements
- R1: After reset no entry is valid, every lookup misses, `inv_ready` is 1 and `inv_done` is 0.
- R2: With `ctx_sl_en` = 0, a lookup hits and returns the stored physical page only when an entry created with second-level translation off has the same VPID and the same linear page as the lookup.
- R3: With `ctx_sl_en` = 1, the root field (pointer bits 51:12, given on `ctx_root_pfn`) must also equal the one recorded at fill time. An entry filled with the mode off never serves a lookup with the mode on, and the reverse holds too.
- R4: Kind 0 (single page) clears only the entries whose VPID and linear page both equal the command's, global or not.
- R5: Kind 1 (one context, globals too) clears every entry carrying the command VPID and leaves entries of other VPIDs.
- R6: Kind 2 (everything) clears every entry whatever its VPID; when its done pulse is high, no entry is valid.
- R7: Kind 3 (one context, globals kept) clears the entries carrying the command VPID except those with the global flag set.
- R8: A command is accepted on a clock edge where `inv_valid` and `inv_ready` are both 1. `inv_ready` is then 0 for the sweep, and `inv_done` is high for exactly one cycle, ENTRIES cycles after the cycle that follows the accepting edge. A command offered while `inv_ready` is 0 is ignored.
- R9: A lookup in the same cycle in which the sweep clears the matching entry reports a miss. An entry the sweep has not reached still hits.
- R10: A fill whose context and page equal a resident entry overwrites that entry in place, so no two entries can hit at once. Otherwise the fill takes the lowest-numbered invalid slot.
- R11: When every slot is valid and no entry matches, the fill replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on such replacements.
- R12: A fill presented while a sweep is running is dropped.
- R13: VPID 0 is an ordinary tag value that hits and is invalidated like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_vpid | input | 16 | VPID of the current context |
| ctx_sl_en | input | 1 | Second-level translation active for the current context |
| ctx_root_pfn | input | 40 | Bits 51:12 of the current second-level root pointer |
| lk_page | input | 36 | Linear page number to translate |
| lk_hit | output | 1 | Lookup found a live entry |
| lk_ppn | output | 40 | Physical page of the hit, 0 on a miss |
| fill_en | input | 1 | Install a translation this cycle |
| fill_page | input | 36 | Linear page of the new translation |
| fill_ppn | input | 40 | Physical page of the new translation |
| fill_global | input | 1 | Global flag of the new translation |
| inv_valid | input | 1 | Invalidation command offered |
| inv_ready | output | 1 | Engine idle, command may be accepted |
| inv_kind | input | 2 | 0 single page, 1 context with globals, 2 all, 3 context keeping globals |
| inv_vpid | input | 16 | VPID named by the command |
| inv_page | input | 36 | Linear page named by a kind 0 command |
| inv_done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
On every cycle, the embedded properties check that ready falls after an accepted command and that done lasts a single cycle. They also check that an everything sweep leaves no valid entry, that fills add nothing while the engine is busy, that at most one entry hits, and that a new translation lands on a free slot whenever one exists. Only the scenarios can show which entries each kind removes, the exact done latency, the context matching with and without second-level translation, the round-robin eviction order and the miss reported by a lookup that races the clear of its own entry.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

   // Invalidation kinds; the code values are part of the command interface.
   typedef enum logic [1:0] {
      INV_ONE_PAGE   = 2'd0,
      INV_CTX_ALL    = 2'd1,
      INV_EVERYTHING = 2'd2,
      INV_CTX_KEEPG  = 2'd3
   } inv_kind_e;

endpackage

// File: rtl/ctx_tlb_sweep.sv
module ctx_tlb_sweep
   import ctx_tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPID_W  = 16,
   parameter int LPN_W   = 36
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  inv_kind_e            cmd_kind,
   input  logic [VPID_W-1:0]    cmd_vpid,
   input  logic [LPN_W-1:0]     cmd_page,
   input  logic [ENTRIES-1:0]   ent_valid,
   input  logic [ENTRIES-1:0]   ent_glb,
   input  logic [VPID_W-1:0]    ent_vpid [ENTRIES],
   input  logic [LPN_W-1:0]     ent_page [ENTRIES],
   output logic                 cmd_ready,
   output logic                 cmd_done,
   output logic                 busy,
   output logic [ENTRIES-1:0]   clr_vec
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic               busy_q, done_q;
   logic [IDX_W-1:0]   idx_q;
   inv_kind_e          kind_q;
   logic [VPID_W-1:0]  vpid_q;
   logic [LPN_W-1:0]   page_q;
   logic               sel_cur;

   always_comb begin
      logic vid_eq;
      vid_eq = (ent_vpid[idx_q] == vpid_q);
      unique case (kind_q)
         INV_ONE_PAGE:   sel_cur = vid_eq && (ent_page[idx_q] == page_q);
         INV_CTX_ALL:    sel_cur = vid_eq;
         INV_EVERYTHING: sel_cur = 1'b1;
         INV_CTX_KEEPG:  sel_cur = vid_eq && !ent_glb[idx_q];
         default:        sel_cur = 1'b0;
      endcase
      clr_vec = '0;
      if (busy_q && ent_valid[idx_q] && sel_cur) clr_vec[idx_q] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
         kind_q <= INV_ONE_PAGE;
         vpid_q <= '0;
         page_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (cmd_valid) begin
               busy_q <= 1'b1;
               idx_q  <= '0;
               kind_q <= cmd_kind;
               vpid_q <= cmd_vpid;
               page_q <= cmd_page;
            end
         end else if (idx_q == LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign cmd_ready = !busy_q;
   assign cmd_done  = done_q;
   assign busy      = busy_q;

   // R8
   ready_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> !cmd_done);

   // R6
   all_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_done && kind_q == INV_EVERYTHING) |-> (ent_valid == '0));

endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
   parameter int ENTRIES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fill_we,
   input  logic [ENTRIES-1:0]   valid_vec,
   input  logic [ENTRIES-1:0]   match_vec,
   output logic [$clog2(ENTRIES)-1:0] slot
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] rr_q, m_idx, f_idx;
   logic             any_m, any_f;

   always_comb begin
      m_idx = '0;
      f_idx = '0;
      any_m = |match_vec;
      any_f = !(&valid_vec);
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_vec[i])  m_idx = IDX_W'(i);
         if (!valid_vec[i]) f_idx = IDX_W'(i);
      end
      if (any_m)      slot = m_idx;
      else if (any_f) slot = f_idx;
      else            slot = rr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rr_q <= '0;
      else if (fill_we && !any_m && !any_f)
         rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
   end

   // R10
   free_slot_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_we && match_vec == '0 && !(&valid_vec)) |-> !valid_vec[slot]);

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
   import ctx_tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPID_W  = 16,
   parameter int LPN_W   = 36,
   parameter int PPN_W   = 40,
   parameter int ROOT_W  = 40
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [VPID_W-1:0]   ctx_vpid,
   input  logic                ctx_sl_en,
   input  logic [ROOT_W-1:0]   ctx_root_pfn,
   input  logic [LPN_W-1:0]    lk_page,
   output logic                lk_hit,
   output logic [PPN_W-1:0]    lk_ppn,
   input  logic                fill_en,
   input  logic [LPN_W-1:0]    fill_page,
   input  logic [PPN_W-1:0]    fill_ppn,
   input  logic                fill_global,
   input  logic                inv_valid,
   output logic                inv_ready,
   input  logic [1:0]          inv_kind,
   input  logic [VPID_W-1:0]   inv_vpid,
   input  logic [LPN_W-1:0]    inv_page,
   output logic                inv_done
);
   localparam int IDX_W = $clog2(ENTRIES);

   generate
      if (ENTRIES < 2) begin : g_bad_depth
         $error("ctx_tlb: ENTRIES must be at least 2");
      end
      if (VPID_W < 1 || LPN_W < 1 || PPN_W < 1 || ROOT_W < 1) begin : g_bad_width
         $error("ctx_tlb: field widths must be positive");
      end
   endgenerate

   logic [ENTRIES-1:0] e_v, e_sl, e_glb;
   logic [VPID_W-1:0]  e_vpid [ENTRIES];
   logic [ROOT_W-1:0]  e_root [ENTRIES];
   logic [LPN_W-1:0]   e_page [ENTRIES];
   logic [PPN_W-1:0]   e_ppn  [ENTRIES];

   logic [ENTRIES-1:0] ctx_eq, lk_vec, fill_vec, clr_vec;
   logic               busy, fill_go;
   logic [IDX_W-1:0]   slot;

   assign fill_go = fill_en && !busy;

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
         assign ctx_eq[i]   = e_v[i] && (e_vpid[i] == ctx_vpid) && (e_sl[i] == ctx_sl_en)
                              && (!ctx_sl_en || e_root[i] == ctx_root_pfn);
         assign lk_vec[i]   = ctx_eq[i] && (e_page[i] == lk_page) && !clr_vec[i];
         assign fill_vec[i] = ctx_eq[i] && (e_page[i] == fill_page);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               e_v[i]    <= 1'b0;
               e_sl[i]   <= 1'b0;
               e_glb[i]  <= 1'b0;
               e_vpid[i] <= '0;
               e_root[i] <= '0;
               e_page[i] <= '0;
               e_ppn[i]  <= '0;
            end else if (clr_vec[i]) begin
               e_v[i] <= 1'b0;
            end else if (fill_go && slot == IDX_W'(i)) begin
               e_v[i]    <= 1'b1;
               e_sl[i]   <= ctx_sl_en;
               e_glb[i]  <= fill_global;
               e_vpid[i] <= ctx_vpid;
               e_root[i] <= ctx_sl_en ? ctx_root_pfn : '0;
               e_page[i] <= fill_page;
               e_ppn[i]  <= fill_ppn;
            end
         end
      end
   endgenerate

   always_comb begin
      lk_ppn = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (lk_vec[i]) lk_ppn |= e_ppn[i];
   end
   assign lk_hit = |lk_vec;

   ctx_tlb_sweep #(
      .ENTRIES (ENTRIES),
      .VPID_W  (VPID_W),
      .LPN_W   (LPN_W)
   ) u_sweep (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (inv_valid),
      .cmd_kind  (inv_kind_e'(inv_kind)),
      .cmd_vpid  (inv_vpid),
      .cmd_page  (inv_page),
      .ent_valid (e_v),
      .ent_glb   (e_glb),
      .ent_vpid  (e_vpid),
      .ent_page  (e_page),
      .cmd_ready (inv_ready),
      .cmd_done  (inv_done),
      .busy      (busy),
      .clr_vec   (clr_vec)
   );

   ctx_tlb_victim #(
      .ENTRIES (ENTRIES)
   ) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_we   (fill_go),
      .valid_vec (e_v),
      .match_vec (fill_vec),
      .slot      (slot)
   );

   // R10
   one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_vec));

   // R12
   no_fill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((e_v & ~$past(e_v)) == '0));

endmodule

// File: tb/ctx_tlb_bench.sv
module ctx_tlb_bench;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ctx_vpid = '0;
   logic        ctx_sl_en = 1'b0;
   logic [39:0] ctx_root_pfn = '0;
   logic [35:0] lk_page = '0;
   logic        lk_hit;
   logic [39:0] lk_ppn;
   logic        fill_en = 1'b0;
   logic [35:0] fill_page = '0;
   logic [39:0] fill_ppn = '0;
   logic        fill_global = 1'b0;
   logic        inv_valid = 1'b0;
   logic        inv_ready;
   logic [1:0]  inv_kind = '0;
   logic [15:0] inv_vpid = '0;
   logic [35:0] inv_page = '0;
   logic        inv_done;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   ctx_tlb u_ctx_tlb (
      .clk(clk), .rst_n(rst_n), .ctx_vpid(ctx_vpid), .ctx_sl_en(ctx_sl_en),
      .ctx_root_pfn(ctx_root_pfn), .lk_page(lk_page), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
      .fill_en(fill_en), .fill_page(fill_page), .fill_ppn(fill_ppn),
      .fill_global(fill_global), .inv_valid(inv_valid), .inv_ready(inv_ready),
      .inv_kind(inv_kind), .inv_vpid(inv_vpid), .inv_page(inv_page), .inv_done(inv_done)
   );

   localparam logic [39:0] RA = 40'h12345;
   localparam logic [39:0] RB = 40'h67890;
   localparam logic [39:0] RC = 40'h12346;

   typedef struct packed {
      logic [15:0] vpid;
      logic        sl;
      logic [39:0] root;
      logic [35:0] page;
      logic        hit;
      logic [39:0] ppn;
   } look_t;

   localparam look_t LTAB [8] = '{
      '{16'd5, 1'b0, 40'h0, 36'h10, 1'b1, 40'hA10},
      '{16'd0, 1'b0, 40'h0, 36'h10, 1'b1, 40'hB10},
      '{16'd7, 1'b0, 40'h0, 36'h10, 1'b0, 40'h0},
      '{16'd5, 1'b0, 40'h0, 36'h11, 1'b0, 40'h0},
      '{16'd5, 1'b1, RA,    36'h10, 1'b1, 40'hC10},
      '{16'd5, 1'b1, RB,    36'h10, 1'b1, 40'hD10},
      '{16'd5, 1'b1, RC,    36'h10, 1'b0, 40'h0},
      '{16'd0, 1'b1, RA,    36'h10, 1'b0, 40'h0}
   };
   localparam string LREQ [8] = '{"R2", "R13", "R2", "R2", "R3", "R3", "R3", "R3"};

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic set_ctx(input logic [15:0] v, input logic sl, input logic [39:0] r);
      ctx_vpid = v; ctx_sl_en = sl; ctx_root_pfn = r;
   endtask

   task automatic look(input logic [15:0] v, input logic sl, input logic [39:0] r,
                       input logic [35:0] pg, input bit eh, input logic [39:0] ep,
                       input string req);
      @(negedge clk);
      set_ctx(v, sl, r);
      lk_page = pg;
      #0.5;
      check(lk_hit == eh, req, $sformatf("hit vpid=%0d page=%0h", v, pg), 64'(lk_hit), 64'(eh));
      if (eh) check(lk_ppn == ep, req, $sformatf("ppn page=%0h", pg), 64'(lk_ppn), 64'(ep));
   endtask

   task automatic fill(input logic [15:0] v, input logic sl, input logic [39:0] r,
                       input logic [35:0] pg, input logic [39:0] pp, input logic g);
      @(negedge clk);
      set_ctx(v, sl, r);
      fill_page = pg; fill_ppn = pp; fill_global = g; fill_en = 1'b1;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic invalidate(input logic [1:0] k, input logic [15:0] v,
                             input logic [35:0] pg, input string req);
      int cyc;
      @(negedge clk);
      inv_kind = k; inv_vpid = v; inv_page = pg; inv_valid = 1'b1;
      @(negedge clk);
      inv_valid = 1'b0;
      check(inv_ready == 1'b0, "R8", {req, " ready low in sweep"}, 64'(inv_ready), 64'd0);
      cyc = 0;
      while (!inv_done && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
      check(cyc == 16, "R8", {req, " done latency"}, 64'(cyc), 64'd16);
      @(negedge clk);
      check(inv_done == 1'b0, "R8", {req, " done one cycle"}, 64'(inv_done), 64'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      check(inv_ready == 1'b1, "R1", "ready after reset", 64'(inv_ready), 64'd1);
      check(inv_done == 1'b0, "R1", "done after reset", 64'(inv_done), 64'd0);
      look(16'd0, 1'b0, 40'h0, 36'h0, 1'b0, 40'h0, "R1");

      // Table walk: R2, R3, R13
      fill(16'd5, 1'b0, 40'h0, 36'h10, 40'hA10, 1'b0);
      fill(16'd0, 1'b0, 40'h0, 36'h10, 40'hB10, 1'b0);
      fill(16'd5, 1'b1, RA,    36'h10, 40'hC10, 1'b0);
      fill(16'd5, 1'b1, RB,    36'h10, 40'hD10, 1'b0);
      for (int i = 0; i < 8; i++)
         look(LTAB[i].vpid, LTAB[i].sl, LTAB[i].root, LTAB[i].page,
              LTAB[i].hit, LTAB[i].ppn, LREQ[i]);

      // R6: everything kind empties the table
      invalidate(2'd2, 16'd9, 36'h0, "R6");
      for (int i = 0; i < 8; i++)
         look(LTAB[i].vpid, LTAB[i].sl, LTAB[i].root, LTAB[i].page, 1'b0, 40'h0, "R6");

      // Kind-by-kind selection
      fill(16'd3, 1'b0, 40'h0, 36'h20, 40'hE20, 1'b1);
      fill(16'd3, 1'b0, 40'h0, 36'h21, 40'hF21, 1'b0);
      fill(16'd4, 1'b0, 40'h0, 36'h20, 40'h420, 1'b0);
      fill(16'd3, 1'b0, 40'h0, 36'h22, 40'hF22, 1'b0);
      invalidate(2'd0, 16'd3, 36'h21, "R4");
      look(16'd3, 1'b0, 40'h0, 36'h21, 1'b0, 40'h0, "R4");
      look(16'd3, 1'b0, 40'h0, 36'h20, 1'b1, 40'hE20, "R4");
      look(16'd3, 1'b0, 40'h0, 36'h22, 1'b1, 40'hF22, "R4");
      look(16'd4, 1'b0, 40'h0, 36'h20, 1'b1, 40'h420, "R4");
      invalidate(2'd3, 16'd3, 36'h0, "R7");
      look(16'd3, 1'b0, 40'h0, 36'h22, 1'b0, 40'h0, "R7");
      look(16'd3, 1'b0, 40'h0, 36'h20, 1'b1, 40'hE20, "R7");
      look(16'd4, 1'b0, 40'h0, 36'h20, 1'b1, 40'h420, "R7");
      invalidate(2'd1, 16'd3, 36'h0, "R5");
      look(16'd3, 1'b0, 40'h0, 36'h20, 1'b0, 40'h0, "R5");
      look(16'd4, 1'b0, 40'h0, 36'h20, 1'b1, 40'h420, "R5");
      invalidate(2'd2, 16'd4, 36'h0, "R6");
      look(16'd4, 1'b0, 40'h0, 36'h20, 1'b0, 40'h0, "R6");

      // R10: in-place overwrite, then free slots in order
      fill(16'd3, 1'b0, 40'h0, 36'h30, 40'h1, 1'b0);
      fill(16'd3, 1'b0, 40'h0, 36'h30, 40'h2, 1'b0);
      look(16'd3, 1'b0, 40'h0, 36'h30, 1'b1, 40'h2, "R10");
      for (int k = 1; k < 16; k++)
         fill(16'd3, 1'b0, 40'h0, 36'h30 + 36'(k), 40'h100 + 40'(k), 1'b0);
      look(16'd3, 1'b0, 40'h0, 36'h30, 1'b1, 40'h2, "R10");
      look(16'd3, 1'b0, 40'h0, 36'h3F, 1'b1, 40'h10F, "R10");

      // R11: round-robin eviction from slot 0 upward
      fill(16'd3, 1'b0, 40'h0, 36'h100, 40'h900, 1'b0);
      look(16'd3, 1'b0, 40'h0, 36'h30, 1'b0, 40'h0, "R11");
      look(16'd3, 1'b0, 40'h0, 36'h31, 1'b1, 40'h101, "R11");
      fill(16'd3, 1'b0, 40'h0, 36'h101, 40'h901, 1'b0);
      look(16'd3, 1'b0, 40'h0, 36'h31, 1'b0, 40'h0, "R11");
      look(16'd3, 1'b0, 40'h0, 36'h32, 1'b1, 40'h102, "R11");
      invalidate(2'd0, 16'd3, 36'h35, "R4");
      fill(16'd3, 1'b0, 40'h0, 36'h102, 40'h902, 1'b0);
      look(16'd3, 1'b0, 40'h0, 36'h102, 1'b1, 40'h902, "R10");
      look(16'd3, 1'b0, 40'h0, 36'h32, 1'b1, 40'h102, "R10");
      fill(16'd3, 1'b0, 40'h0, 36'h103, 40'h903, 1'b0);
      look(16'd3, 1'b0, 40'h0, 36'h32, 1'b0, 40'h0, "R11");
      look(16'd3, 1'b0, 40'h0, 36'h33, 1'b1, 40'h103, "R11");

      // R9, R8, R12: races against a running sweep (slot 0 holds page 100)
      fill(16'd4, 1'b0, 40'h0, 36'h50, 40'h450, 1'b0);
      begin
         int cyc;
         @(negedge clk);
         set_ctx(16'd3, 1'b0, 40'h0);
         lk_page = 36'h100;
         inv_kind = 2'd1; inv_vpid = 16'd3; inv_page = '0; inv_valid = 1'b1;
         #0.5;
         check(lk_hit == 1'b1, "R9", "hit before sweep", 64'(lk_hit), 64'd1);
         @(negedge clk);
         inv_valid = 1'b0;
         #0.5;
         check(lk_hit == 1'b0, "R9", "miss while slot cleared", 64'(lk_hit), 64'd0);
         lk_page = 36'h101;
         #0.5;
         check(lk_hit == 1'b1, "R9", "later slot still hits", 64'(lk_hit), 64'd1);
         check(inv_ready == 1'b0, "R8", "ready low in sweep", 64'(inv_ready), 64'd0);
         cyc = 0;
         @(negedge clk);
         cyc++;
         set_ctx(16'd9, 1'b0, 40'h0);
         fill_page = 36'h200; fill_ppn = 40'h200; fill_global = 1'b0; fill_en = 1'b1;
         inv_kind = 2'd2; inv_valid = 1'b1;
         @(negedge clk);
         cyc++;
         fill_en = 1'b0;
         inv_valid = 1'b0;
         while (!inv_done && cyc < 100) begin
            @(negedge clk);
            cyc++;
         end
         check(cyc == 16, "R8", "done latency with traffic", 64'(cyc), 64'd16);
      end
      repeat (20) @(negedge clk);
      check(inv_ready == 1'b1, "R8", "ignored command left engine idle", 64'(inv_ready), 64'd1);
      look(16'd9, 1'b0, 40'h0, 36'h200, 1'b0, 40'h0, "R12");
      look(16'd4, 1'b0, 40'h0, 36'h50, 1'b1, 40'h450, "R8");
      look(16'd3, 1'b0, 40'h0, 36'h101, 1'b0, 40'h0, "R5");

      // R13: VPID 0 invalidated like any other
      fill(16'd0, 1'b0, 40'h0, 36'h77, 40'h777, 1'b0);
      look(16'd0, 1'b0, 40'h0, 36'h77, 1'b1, 40'h777, "R13");
      invalidate(2'd1, 16'd0, 36'h0, "R13");
      look(16'd0, 1'b0, 40'h0, 36'h77, 1'b0, 40'h0, "R13");
      look(16'd4, 1'b0, 40'h0, 36'h50, 1'b1, 40'h450, "R13");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule